// File: doc/BRIEF.md
# Memory-Mapped Compare Timer Frame

This block is one timer frame attached to a free-running 64-bit system count. It offers two views of that count. The physical view is the count itself. The virtual view is the count minus a 64-bit offset that software programs. Each view has its own comparator, and each comparator drives a level-sensitive interrupt line.

Software can program a comparator in two ways. It can write an absolute 64-bit compare value, or it can write a signed 32-bit countdown, which the block adds to the current count. Reading the countdown register returns the distance from the current count to the compare value. A comparator's condition holds once its count has reached or passed the compare value. Its interrupt is raised only while the comparator is enabled and not masked.

All registers are reached through a simple 32-bit word bus that has separate read and write strobes and a registered read-data port.

Top module: `cmp_timer_frame`

## Requirements
- R1: While `rst` is high, and after it falls, every programmable register reads 0, both interrupt outputs are 0 and `rdata` is 0.
- R2: Byte offset 0x00 returns bits 31:0 of `sys_count` and offset 0x04 returns bits 63:32. Writes to offsets 0x00, 0x04, 0x08 and 0x0C change nothing.
- R3: The virtual count is `sys_count` minus the virtual offset. Its low word reads at 0x08 and its high word at 0x0C. The offset is read/write, with the low word at 0x18 and the high word at 0x1C.
- R4: The frequency word at 0x10 and the user-access word at 0x14 are plain 32-bit read/write storage with no other effect.
- R5: The physical compare value is read/write at 0x20 (low word) and 0x24 (high word). The virtual compare value is at 0x30 and 0x34 in the same way.
- R6: Reading the countdown register (physical 0x28, virtual 0x38) returns the compare value minus the matching count, truncated to 32 bits.
- R7: Writing a countdown register sets that compare value to the matching count plus the written word, sign-extended to 64 bits.
- R8: In a control word (physical 0x2C, virtual 0x3C), bit 0 is enable and bit 1 is mask; both are read/write. Bit 2 is read-only status, equal to enable AND (count >= compare value, unsigned). All other bits read 0.
- R9: An interrupt output is 1 in the cycle after a clock edge at which enable=1, mask=0 and count >= compare value all held. Otherwise it is 0, so it falls one cycle after any of these stops holding.
- R10: Offsets 0x40 and above read as 0, and writes to them change no register.
- R11: Read data appears on `rdata` in the cycle after the one in which `rd_en` is sampled high. It holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_count | input | 64 | Free-running system count |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (8) | Byte offset, word aligned |
| wdata | input | BUS_W (32) | Write data |
| rdata | output | BUS_W (32) | Registered read data |
| irq_phys | output | 1 | Physical comparator interrupt, level |
| irq_virt | output | 1 | Virtual comparator interrupt, level |

## Verification
The bench sets a negative countdown that lands the compare value below the count. A design that zero-extended the countdown would put the limit about four billion ticks ahead, and no interrupt would fire. It raises a compare value's high word above the count while the low word stays behind it. A comparator that looked only at 32 bits would then keep its interrupt high. It tries to set the status bit, writes to the count words and writes above 0x3C, then reads everything back. A design that stored any of these writes, or aliased the upper offsets onto the map, would show changed values. It toggles mask and enable with the condition held, and it resets mid-run. A design whose interrupt latched, ignored the mask, or lagged by a different number of cycles would differ from the model on the exact cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Word indices (byte offset >> 2) inside the 64-byte map.
  localparam logic [3:0] WI_PCNT_LO = 4'h0;
  localparam logic [3:0] WI_PCNT_HI = 4'h1;
  localparam logic [3:0] WI_VCNT_LO = 4'h2;
  localparam logic [3:0] WI_VCNT_HI = 4'h3;
  localparam logic [3:0] WI_FREQ    = 4'h4;
  localparam logic [3:0] WI_UACC    = 4'h5;
  localparam logic [3:0] WI_VOFF_LO = 4'h6;
  localparam logic [3:0] WI_VOFF_HI = 4'h7;
  // Comparator block: bit 2 of the index selects the channel, bits 1:0 the register.
  localparam logic [1:0] CR_CMP_LO  = 2'd0;
  localparam logic [1:0] CR_CMP_HI  = 2'd1;
  localparam logic [1:0] CR_CDOWN   = 2'd2;
  localparam logic [1:0] CR_CTRL    = 2'd3;
  // Control word bit positions.
  localparam int CTL_EN   = 0;
  localparam int CTL_MASK = 1;
  localparam int CTL_STAT = 2;
  // Channel numbering.
  localparam int CH_PHYS = 0;
  localparam int CH_VIRT = 1;
  localparam int NUM_CH  = 2;
endpackage

// File: rtl/tmr_comparator.sv
module tmr_comparator
  import tmr_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2*BUS_W-1:0] count_i,
  input  logic [BUS_W-1:0]   wdata_i,
  input  logic               cmp_lo_we,
  input  logic               cmp_hi_we,
  input  logic               cdown_we,
  input  logic               ctrl_we,
  output logic [2*BUS_W-1:0] cmp_o,
  output logic [BUS_W-1:0]   cdown_o,
  output logic [BUS_W-1:0]   ctrl_o,
  output logic               irq_o
);
  localparam int CNT_W = 2 * BUS_W;

  logic [CNT_W-1:0] cmp_q;
  logic             en_q;
  logic             mask_q;
  logic             irq_q;
  logic             reached;
  logic [CNT_W-1:0] cdown_sext;

  assign reached    = (count_i >= cmp_q);
  assign cdown_sext = {{BUS_W{wdata_i[BUS_W-1]}}, wdata_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '0;
      en_q   <= 1'b0;
      mask_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= en_q & ~mask_q & reached;
      if (cdown_we) begin
        cmp_q <= count_i + cdown_sext;
      end else begin
        if (cmp_lo_we) cmp_q[BUS_W-1:0]     <= wdata_i;
        if (cmp_hi_we) cmp_q[CNT_W-1:BUS_W] <= wdata_i;
      end
      if (ctrl_we) begin
        en_q   <= wdata_i[CTL_EN];
        mask_q <= wdata_i[CTL_MASK];
      end
    end
  end

  always_comb begin
    ctrl_o           = '0;
    ctrl_o[CTL_EN]   = en_q;
    ctrl_o[CTL_MASK] = mask_q;
    ctrl_o[CTL_STAT] = en_q & reached;
  end

  assign cmp_o   = cmp_q;
  assign cdown_o = cmp_q[BUS_W-1:0] - count_i[BUS_W-1:0];
  assign irq_o   = irq_q;

  // R9
  irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(en_q && !mask_q));
  // R9
  irq_reached_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(count_i >= cmp_q));
  // R7
  cdown_load_chk: assert property (@(posedge clk) disable iff (rst)
    cdown_we |=> cmp_q == $past(count_i) + {{BUS_W{$past(wdata_i[BUS_W-1])}}, $past(wdata_i)});
  // R8
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_we |=> $stable(en_q) && $stable(mask_q));
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
  import tmr_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic                            mapped_i,
  input  logic [3:0]                      widx_i,
  input  logic [2*BUS_W-1:0]              pcnt_i,
  input  logic [2*BUS_W-1:0]              vcnt_i,
  input  logic [BUS_W-1:0]                freq_i,
  input  logic [BUS_W-1:0]                uacc_i,
  input  logic [2*BUS_W-1:0]              voff_i,
  input  logic [NUM_CH-1:0][2*BUS_W-1:0]  cmp_i,
  input  logic [NUM_CH-1:0][BUS_W-1:0]    cdown_i,
  input  logic [NUM_CH-1:0][BUS_W-1:0]    ctrl_i,
  output logic [BUS_W-1:0]                data_o
);
  localparam int CNT_W = 2 * BUS_W;

  logic        ch;
  logic [1:0]  creg;

  assign ch   = widx_i[2];
  assign creg = widx_i[1:0];

  always_comb begin
    data_o = '0;
    if (mapped_i) begin
      if (widx_i[3]) begin
        unique case (creg)
          CR_CMP_LO: data_o = cmp_i[ch][BUS_W-1:0];
          CR_CMP_HI: data_o = cmp_i[ch][CNT_W-1:BUS_W];
          CR_CDOWN:  data_o = cdown_i[ch];
          default:   data_o = ctrl_i[ch];
        endcase
      end else begin
        unique case (widx_i)
          WI_PCNT_LO: data_o = pcnt_i[BUS_W-1:0];
          WI_PCNT_HI: data_o = pcnt_i[CNT_W-1:BUS_W];
          WI_VCNT_LO: data_o = vcnt_i[BUS_W-1:0];
          WI_VCNT_HI: data_o = vcnt_i[CNT_W-1:BUS_W];
          WI_FREQ:    data_o = freq_i;
          WI_UACC:    data_o = uacc_i;
          WI_VOFF_LO: data_o = voff_i[BUS_W-1:0];
          default:    data_o = voff_i[CNT_W-1:BUS_W];
        endcase
      end
    end
  end
endmodule

// File: rtl/cmp_timer_frame.sv
module cmp_timer_frame
  import tmr_pkg::*;
#(
  parameter int          BUS_W    = 32,
  parameter int          ADDR_W   = 8,
  parameter logic [31:0] FREQ_RST = 32'h0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2*BUS_W-1:0]   sys_count,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BUS_W-1:0]     wdata,
  output logic [BUS_W-1:0]     rdata,
  output logic                 irq_phys,
  output logic                 irq_virt
);
  localparam int CNT_W   = 2 * BUS_W;
  localparam int WORD_LO = 2;
  localparam int WORD_HI = WORD_LO + 3;

  logic [3:0]       widx;
  logic             mapped;
  logic             wr_hit;
  logic [CNT_W-1:0] voff_q;
  logic [BUS_W-1:0] freq_q;
  logic [BUS_W-1:0] uacc_q;
  logic [CNT_W-1:0] vcnt;
  logic [BUS_W-1:0] rd_mux;
  logic [BUS_W-1:0] rdata_q;

  logic [NUM_CH-1:0][CNT_W-1:0] ch_count;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_cmp;
  logic [NUM_CH-1:0][BUS_W-1:0] ch_cdown;
  logic [NUM_CH-1:0][BUS_W-1:0] ch_ctrl;
  logic [NUM_CH-1:0]            ch_irq;

  assign widx   = addr[WORD_HI:WORD_LO];
  assign mapped = (addr[ADDR_W-1:WORD_HI+1] == '0);
  assign wr_hit = wr_en & mapped;
  assign vcnt   = sys_count - voff_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      voff_q <= '0;
      freq_q <= FREQ_RST[BUS_W-1:0];
      uacc_q <= '0;
    end else if (wr_hit && !widx[3]) begin
      case (widx)
        WI_FREQ:    freq_q                <= wdata;
        WI_UACC:    uacc_q                <= wdata;
        WI_VOFF_LO: voff_q[BUS_W-1:0]     <= wdata;
        WI_VOFF_HI: voff_q[CNT_W-1:BUS_W] <= wdata;
        default:    ;
      endcase
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      logic sel;
      assign sel         = wr_hit && widx[3] && (widx[2] == g[0]);
      assign ch_count[g] = (g == CH_PHYS) ? sys_count : vcnt;

      tmr_comparator #(.BUS_W(BUS_W)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .count_i   (ch_count[g]),
        .wdata_i   (wdata),
        .cmp_lo_we (sel && widx[1:0] == CR_CMP_LO),
        .cmp_hi_we (sel && widx[1:0] == CR_CMP_HI),
        .cdown_we  (sel && widx[1:0] == CR_CDOWN),
        .ctrl_we   (sel && widx[1:0] == CR_CTRL),
        .cmp_o     (ch_cmp[g]),
        .cdown_o   (ch_cdown[g]),
        .ctrl_o    (ch_ctrl[g]),
        .irq_o     (ch_irq[g])
      );
    end
  endgenerate

  tmr_rdmux #(.BUS_W(BUS_W)) u_rdmux (
    .mapped_i (mapped),
    .widx_i   (widx),
    .pcnt_i   (sys_count),
    .vcnt_i   (vcnt),
    .freq_i   (freq_q),
    .uacc_i   (uacc_q),
    .voff_i   (voff_q),
    .cmp_i    (ch_cmp),
    .cdown_i  (ch_cdown),
    .ctrl_i   (ch_ctrl),
    .data_o   (rd_mux)
  );

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata    = rdata_q;
  assign irq_phys = ch_irq[CH_PHYS];
  assign irq_virt = ch_irq[CH_VIRT];

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr[ADDR_W-1:WORD_HI+1] != '0) |=> rdata == '0);
  // R3
  vcnt_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(8'h08)) |=> rdata == $past(sys_count[BUS_W-1:0]) - $past(voff_q[BUS_W-1:0]));
  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata_q));
  // R2
  pcnt_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(8'h04)) |=> rdata == $past(sys_count[CNT_W-1:BUS_W]));
endmodule

// File: tb/cmp_timer_frame_bench.sv
`timescale 1ns/1ps
module cmp_timer_frame_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] sys_count = 64'h0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = 8'h0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic        irq_phys;
  logic        irq_virt;

  cmp_timer_frame u_cmp_timer_frame (
    .clk(clk), .rst(rst), .sys_count(sys_count), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_phys(irq_phys), .irq_virt(irq_virt)
  );

  always #2 clk = ~clk;

  // Reference model state
  longint unsigned m_voff, m_cmp[2];
  int unsigned     m_freq, m_uacc;
  bit              m_en[2], m_mask[2];
  bit              e_irq[2];
  int unsigned     e_rdata;
  bit              started = 0;
  int              checks = 0, fails = 0, cyc = 0;
  string           cur_req = "R1";

  function automatic longint unsigned cnt_of(int ch);
    return (ch == 0) ? sys_count : sys_count - m_voff;
  endfunction

  function automatic int unsigned model_read(logic [7:0] a);
    int ch;
    longint unsigned v;
    if (a >= 8'h40) return 0;
    if (a >= 8'h20) begin
      ch = (a >= 8'h30) ? 1 : 0;
      case (a[3:0])
        4'h0: return m_cmp[ch][31:0];
        4'h4: return m_cmp[ch][63:32];
        4'h8: begin v = m_cmp[ch] - cnt_of(ch); return v[31:0]; end
        default: return {29'd0, m_en[ch] && (cnt_of(ch) >= m_cmp[ch]), m_mask[ch], m_en[ch]};
      endcase
    end
    case (a)
      8'h00: return sys_count[31:0];
      8'h04: return sys_count[63:32];
      8'h08: begin v = cnt_of(1); return v[31:0]; end
      8'h0C: begin v = cnt_of(1); return v[63:32]; end
      8'h10: return m_freq;
      8'h14: return m_uacc;
      8'h18: return m_voff[31:0];
      default: return m_voff[63:32];
    endcase
  endfunction

  always @(posedge clk) begin
    started <= 1;
    cyc <= cyc + 1;
    if (rst) begin
      m_voff = 0; m_freq = 0; m_uacc = 0; e_rdata = 0;
      for (int c = 0; c < 2; c++) begin
        m_cmp[c] = 0; m_en[c] = 0; m_mask[c] = 0; e_irq[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++)
        e_irq[c] = m_en[c] && !m_mask[c] && (cnt_of(c) >= m_cmp[c]);
      if (rd_en) e_rdata = model_read(addr);
      if (wr_en && addr < 8'h40) begin
        if (addr >= 8'h20) begin
          int ch;
          ch = (addr >= 8'h30) ? 1 : 0;
          case (addr[3:0])
            4'h0: m_cmp[ch][31:0]  = wdata;
            4'h4: m_cmp[ch][63:32] = wdata;
            4'h8: m_cmp[ch] = cnt_of(ch) + {{32{wdata[31]}}, wdata};
            default: begin m_en[ch] = wdata[0]; m_mask[ch] = wdata[1]; end
          endcase
        end else begin
          case (addr)
            8'h10: m_freq = wdata;
            8'h14: m_uacc = wdata;
            8'h18: m_voff[31:0] = wdata;
            8'h1C: m_voff[63:32] = wdata;
            default: ;
          endcase
        end
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      checks += 3;
      if (rdata !== e_rdata) begin
        fails++;
        $display("FAIL %s rdata got %08h exp %08h (t=%0t)", cur_req, rdata, e_rdata, $time);
      end
      if (irq_phys !== e_irq[0]) begin
        fails++;
        $display("FAIL %s irq_phys got %b exp %b (t=%0t)", cur_req, irq_phys, e_irq[0], $time);
      end
      if (irq_virt !== e_irq[1]) begin
        fails++;
        $display("FAIL %s irq_virt got %b exp %b (t=%0t)", cur_req, irq_virt, e_irq[1], $time);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog R1 got cycle %0d exp below 20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sys_count = sys_count + 1;
    end
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst = 0;
    sys_count = 64'h0000_0001_2345_6780;
    for (int a = 0; a < 64; a += 4) rd(8'(a));

    cur_req = "R2";
    rd(8'h00); rd(8'h04);
    wr(8'h00, 32'hDEAD); wr(8'h04, 32'h5); wr(8'h08, 32'h7); wr(8'h0C, 32'h9);
    rd(8'h00); rd(8'h04); rd(8'h08); rd(8'h0C);

    cur_req = "R3";
    wr(8'h18, 32'h0000_0100); wr(8'h1C, 32'h0);
    rd(8'h08); rd(8'h0C); rd(8'h18); rd(8'h1C);
    wr(8'h1C, 32'h2);
    rd(8'h0C); wr(8'h1C, 32'h0);

    cur_req = "R4";
    wr(8'h10, 32'h017D_7840); wr(8'h14, 32'h5);
    rd(8'h10); rd(8'h14);

    cur_req = "R5";
    wr(8'h20, 32'h2345_6794); wr(8'h24, 32'h1);
    wr(8'h30, 32'hAAAA_5555); wr(8'h34, 32'h3);
    rd(8'h20); rd(8'h24); rd(8'h30); rd(8'h34);

    cur_req = "R6";
    rd(8'h28); rd(8'h38);

    cur_req = "R9";
    wr(8'h2C, 32'h1);
    step(25);
    rd(8'h2C);
    wr(8'h2C, 32'h3); step(3);
    wr(8'h2C, 32'h1); step(3);
    wr(8'h2C, 32'h0); step(3);

    cur_req = "R8";
    wr(8'h2C, 32'hFFFF_FFFC); rd(8'h2C);
    wr(8'h2C, 32'h7); rd(8'h2C); step(2);

    cur_req = "R7";
    wr(8'h2C, 32'h1);
    wr(8'h28, 32'hFFFF_FFF0);
    rd(8'h28); rd(8'h20); rd(8'h24); step(3);
    wr(8'h28, 32'h0000_0040);
    rd(8'h28); step(70);

    cur_req = "R9";
    wr(8'h3C, 32'h1);
    wr(8'h38, 32'h10);
    step(20);
    rd(8'h3C);
    wr(8'h34, 32'h2); step(3);
    rd(8'h3C); rd(8'h38);

    cur_req = "R10";
    rd(8'h40); rd(8'h80); rd(8'hFC);
    wr(8'h40, 32'hFFFF_FFFF); wr(8'h60, 32'h1234); wr(8'hFC, 32'h3);
    for (int a = 8; a < 64; a += 4) rd(8'(a));

    cur_req = "R11";
    rd(8'h10);
    repeat (4) @(negedge clk);
    wr(8'h10, 32'h1);
    repeat (2) @(negedge clk);

    cur_req = "R1";
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    for (int a = 16; a < 64; a += 4) rd(8'(a));
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule